// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation converter. Writing a channel code starts a conversion. The block first runs a sample phase, during which an external track/hold follows the input. Its length comes from a programmable sample-time value. A binary search then follows, from the most significant bit down to the least significant. On each step the block drives a trial code to an external DAC and reads back one comparator bit.

When the last bit is decided, the block stores the 12-bit word and raises a completion flag. The flag clears when software strobes a result read. A mode bit selects single operation, which is one conversion per channel write, or continuous operation, which re-arms automatically. The all-ones channel code switches the converter off.

Top module: `sar_seq`

## Requirements
- R1: After reset the selected channel reads 0x1F, busy and sample indicators are low, the completion flag is low, and the result and DAC code are zero.
- R2: A channel write with any code other than 0x1F makes busy and the sample indicator high on the next cycle, and the selected channel follows the written code.
- R3: Writing channel code 0x1F starts nothing. If a conversion is running, it stops, and busy is low on the next cycle.
- R4: The sample phase lasts the 8-bit sample-time value plus one cycles. Before any configuration write the value is 12, which gives 13 cycles.
- R5: The first compare cycle drives the DAC code 0x800 (midscale).
- R6: Each compare takes one cycle. The comparator bit is read at the end of the cycle in which the trial code is driven. A high comparator bit (input at or above the DAC level) keeps the trial bit at 1, and a low bit clears it. The next lower bit is then set to 1.
- R7: After the last bit, the result holds the final search word. This equals the input code of an ideal comparator. The result sits in bits 11:0 of the 16-bit read word, and bits 15:12 read zero.
- R8: The completion flag rises when a result is stored and falls on the cycle after a result-read strobe.
- R9: Busy stays high for the whole conversion: sample-time plus 13 cycles in single mode.
- R10: In continuous mode a new sample phase begins right after each result is stored, without another channel write.
- R11: A channel write during a conversion aborts it and starts over on the new channel. The completion flag stays low until the restarted conversion finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_we_i | input | 1 | Channel write strobe |
| chan_i | input | 5 | Channel code written (0x1F = off) |
| cfg_we_i | input | 1 | Configuration write strobe |
| smp_time_i | input | 8 | Sample-time value (phase = value + 1 cycles) |
| cont_i | input | 1 | 1 = continuous, 0 = single |
| rd_result_i | input | 1 | Result-read strobe, clears completion flag |
| cmp_i | input | 1 | Comparator: 1 when input at or above DAC level |
| chan_o | output | 5 | Selected channel to analog mux |
| sample_o | output | 1 | High during sample phase |
| dac_code_o | output | 12 | Trial code to DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion complete |
| result_o | output | 16 | Result read word |

## Verification
Several properties are checked on every cycle. A valid channel write always leads to a sampling cycle, and the off code always leads to idle. The search always enters at midscale. Each compare step stores the comparator bit and raises the next lower bit. The sample counter only counts down. The completion flag only rises out of a busy cycle and falls after a read.

Other behaviour needs whole scenarios to show. The bench checks full conversion lengths, final result values for edge input codes and several sample times, and the reset value of the sample time. It also checks automatic re-arming in continuous mode, and that an aborted or restarted conversion keeps the flag low and converts on the new channel.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } seq_state_e;

  localparam int unsigned SMP_RESET = 12;
endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          run_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);

  p_count_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] code_o,
  output logic         last_o,
  output logic [W-1:0] final_o
);
  localparam int unsigned IW = $clog2(W);

  logic [W-1:0]  sar_q;
  logic [IW-1:0] idx_q;

  always_comb begin
    final_o        = sar_q;
    final_o[idx_q] = cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      sar_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sar_q <= {1'b1, {(W-1){1'b0}}};
      idx_q <= IW'(W-1);
    end else if (step_i) begin
      sar_q[idx_q] <= cmp_i;
      if (idx_q != '0) begin
        sar_q[idx_q - IW'(1)] <= 1'b1;
        idx_q <= idx_q - IW'(1);
      end
    end
  end

  assign code_o = sar_q;
  assign last_o = (idx_q == '0);

  p_keep_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !load_i) |=> (sar_q[$past(idx_q)] == $past(cmp_i)));
  p_next_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && !load_i && idx_q != '0) |=> sar_q[$past(idx_q) - IW'(1)]);
  p_midscale_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i) |=> (sar_q == {1'b1, {(W-1){1'b0}}}));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned CH_W  = 5,
  parameter int unsigned SMP_W = 8,
  parameter int unsigned RD_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_we_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic             cfg_we_i,
  input  logic [SMP_W-1:0] smp_time_i,
  input  logic             cont_i,
  input  logic             rd_result_i,
  input  logic             cmp_i,
  output logic [CH_W-1:0]  chan_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [RD_W-1:0]  result_o
);
  localparam logic [CH_W-1:0] CH_OFF = '1;

  seq_state_e       state_q;
  logic [CH_W-1:0]  chan_q;
  logic [SMP_W-1:0] smp_q;
  logic             cont_q;
  logic             done_q;
  logic [RES_W-1:0] result_q;

  logic start, stop, smp_zero, last, finish;
  logic [RES_W-1:0] final_w;

  assign start  = chan_we_i && (chan_i != CH_OFF);
  assign stop   = chan_we_i && (chan_i == CH_OFF);
  assign finish = !chan_we_i && (state_q == ST_CONV) && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= SMP_W'(SMP_RESET);
      cont_q <= 1'b0;
    end else if (cfg_we_i) begin
      smp_q  <= smp_time_i;
      cont_q <= cont_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chan_q  <= CH_OFF;
    end else if (stop) begin
      state_q <= ST_IDLE;
      chan_q  <= CH_OFF;
    end else if (start) begin
      state_q <= ST_SAMPLE;
      chan_q  <= chan_i;
    end else begin
      case (state_q)
        ST_SAMPLE: if (smp_zero) state_q <= ST_CONV;
        ST_CONV:   if (last) state_q <= cont_q ? ST_SAMPLE : ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      if (finish) result_q <= final_w;
      if (start)            done_q <= 1'b0;
      else if (finish)      done_q <= 1'b1;
      else if (rd_result_i) done_q <= 1'b0;
    end
  end

  sar_timer #(.CW(SMP_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start || (finish && cont_q)),
    .val_i  (smp_q),
    .run_i  (state_q == ST_SAMPLE),
    .zero_o (smp_zero)
  );

  sar_search #(.W(RES_W)) u_search (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (chan_we_i),
    .load_i  (state_q == ST_SAMPLE && smp_zero),
    .step_i  (state_q == ST_CONV),
    .cmp_i   (cmp_i),
    .code_o  (dac_code_o),
    .last_o  (last),
    .final_o (final_w)
  );

  assign chan_o   = chan_q;
  assign sample_o = (state_q == ST_SAMPLE);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = RD_W'(result_q);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (busy_o && sample_o && chan_o == $past(chan_i)));
  p_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (!busy_o && chan_o == CH_OFF));
  p_done_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  p_done_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_result_i && !finish) |=> !done_o);
  p_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && busy_o) |=> (!done_o && sample_o));
  p_rearm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && cont_q) |=> sample_o);
endmodule

// File: tb/sar_seq_tb_top.sv
module sar_seq_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 6;
  localparam logic [11:0] VEC_VIN [NVEC] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'hA5C, 12'h001};
  localparam logic [7:0]  VEC_SMP [NVEC] = '{8'd0, 8'd12, 8'd255, 8'd3, 8'd1, 8'd7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_we = 1'b0, cfg_we = 1'b0, cont = 1'b0, rd = 1'b0;
  logic [4:0] chan = '0;
  logic [7:0] smp = '0;
  logic [11:0] vin = '0;
  logic cmp;
  logic [4:0] chan_o;
  logic sample_o, busy_o, done_o;
  logic [11:0] dac;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator: high when input at or above DAC level
  assign cmp = (vin >= dac);

  sar_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .chan_we_i(chan_we), .chan_i(chan),
    .cfg_we_i(cfg_we), .smp_time_i(smp), .cont_i(cont), .rd_result_i(rd),
    .cmp_i(cmp), .chan_o(chan_o), .sample_o(sample_o), .dac_code_o(dac),
    .busy_o(busy_o), .done_o(done_o), .result_o(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_chan(input logic [4:0] c);
    chan_we = 1'b1; chan = c;
    @(negedge clk);
    chan_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] s, input logic c);
    cfg_we = 1'b1; smp = s; cont = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_res();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // counts busy cycles, checks midscale at entry to compare, done low while busy
  task automatic count_busy(output int n, output int mid_ok, output int done_bad);
    logic prev_s;
    n = 0; mid_ok = 0; done_bad = 0; prev_s = 1'b0;
    while (busy_o) begin
      if (prev_s && !sample_o && dac == 12'h800) mid_ok = 1;
      if (done_o) done_bad = 1;
      prev_s = sample_o;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, mid, dbad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 chan", 32'(chan_o), 32'h1F);
    check("R1 busy", 32'(busy_o), 0);
    check("R1 sample", 32'(sample_o), 0);
    check("R1 done", 32'(done_o), 0);
    check("R1 result", 32'(result), 0);
    check("R1 dac", 32'(dac), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 default sample time 12 -> 13 + 12 = 25 busy cycles
    vin = 12'h3C5;
    wr_chan(5'd1);
    check("R2 busy", 32'(busy_o), 1);
    check("R2 sample", 32'(sample_o), 1);
    check("R2 chan", 32'(chan_o), 1);
    count_busy(n, mid, dbad);
    check("R4 default length", 32'(n), 25);
    check("R7 default result", 32'(result), 32'h3C5);
    check("R8 done set", 32'(done_o), 1);
    read_res();
    check("R8 done cleared", 32'(done_o), 0);

    // vector table: input codes and sample times, single mode
    for (int i = 0; i < NVEC; i++) begin
      wr_cfg(VEC_SMP[i], 1'b0);
      vin = VEC_VIN[i];
      wr_chan(5'(i + 2));
      count_busy(n, mid, dbad);
      check("R9 busy length", 32'(n), 32'(VEC_SMP[i]) + 13);
      check("R5 midscale", 32'(mid), 1);
      check("R6 R7 result", 32'(result), 32'(VEC_VIN[i]));
      check("R7 upper bits", 32'(result[15:12]), 0);
      check("R8 done", 32'(done_o), 1);
      read_res();
      check("R8 read clears", 32'(done_o), 0);
    end

    // R3 off code while idle starts nothing
    wr_chan(5'h1F);
    check("R3 idle off", 32'(busy_o), 0);
    repeat (5) @(negedge clk);
    check("R3 no start", 32'(busy_o), 0);

    // R3 off code aborts a running conversion
    wr_cfg(8'd12, 1'b0);
    vin = 12'h111;
    wr_chan(5'd6);
    repeat (4) @(negedge clk);
    wr_chan(5'h1F);
    check("R3 abort busy", 32'(busy_o), 0);
    check("R3 abort chan", 32'(chan_o), 32'h1F);
    repeat (30) @(negedge clk);
    check("R3 no result", 32'(done_o), 0);
    check("R3 result kept", 32'(result), 32'(VEC_VIN[NVEC-1]));

    // R11 restart on new channel mid-conversion
    vin = 12'h300;
    wr_chan(5'd2);
    repeat (16) @(negedge clk);
    vin = 12'h9AB;
    wr_chan(5'd4);
    check("R11 chan", 32'(chan_o), 4);
    count_busy(n, mid, dbad);
    check("R11 full length", 32'(n), 25);
    check("R11 done low", 32'(dbad), 0);
    check("R11 result", 32'(result), 32'h9AB);
    read_res();

    // R10 continuous mode
    wr_cfg(8'd2, 1'b1);
    vin = 12'h123;
    wr_chan(5'd3);
    n = 0;
    while (!done_o) begin n++; @(negedge clk); end
    check("R10 first length", 32'(n), 15);
    check("R10 first result", 32'(result), 32'h123);
    check("R10 rearmed", 32'(sample_o), 1);
    vin = 12'h456;
    read_res();
    n = 0;
    while (!done_o) begin n++; @(negedge clk); end
    check("R10 second length", 32'(n), 14);
    check("R10 second result", 32'(result), 32'h456);
    wr_chan(5'h1F);
    check("R10 stop", 32'(busy_o), 0);

    finish_run();
  end
endmodule